// File: doc/BRIEF.md
# Dual-Path Bus Ready Sampler

This block sequences the T-states of a simple processor bus cycle (idle, T1, T2, T3, any number of wait states Tw, T4) and decides at the end of each T3 or Tw whether the cycle goes on to T4 or takes another wait state. Two ready inputs can end the wait. The asynchronous ready passes through a two-stage capture and must be seen high twice. The synchronous ready passes through a single capture stage.

The block runs on one clock at twice the processor rate. An internal phase toggle turns alternate rising edges into phase-1 edges and phase-2 edges. T-states change only on phase-2 edges, so every T-state lasts two clock cycles: the first ends on a phase-1 edge and the second on a phase-2 edge. The phase is brought out so that whatever drives the ready inputs can line up with the capture edges. A start input requests a bus cycle. A request that is present when T4 ends chains the next cycle directly.

Top module: `dual_ready_sampler`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is T-state code 0 (idle) and `phase_o` is 0. Both ready capture paths are cleared.
- R2: Out of reset, `phase_o` inverts on every clock edge. `phase_o` = 1 means the coming edge is a phase-2 edge. The T-state may change only on a phase-2 edge, so T1, T2, T3 and each Tw last exactly two clock cycles.
- R3: T-state codes are idle=0, T1=1, T2=2, T3=3, Tw=4, T4=5. Idle moves to T1 on a phase-2 edge where `start_i` is high, and stays idle otherwise. T1 moves to T2 and T2 moves to T3 unconditionally.
- R4: For a given T3 or Tw, the asynchronous path is ready only if `ardy_i` is high at the phase-2 edge that ends the state before it and also high at the phase-1 edge inside it. High at only one of these two edges counts as not ready.
- R5: For a given T3 or Tw, the synchronous path is ready exactly when `srdy_i` is high at the phase-1 edge inside it. Its value at phase-2 edges has no effect.
- R6: At the phase-2 edge that ends a T3 or Tw, the state becomes T4 if either path is ready, and Tw otherwise. The number of wait states is therefore the index of the first T3/Tw (T3 = 0) in which a path is ready.
- R7: `wait_o` is high in exactly the cycles whose T-state is Tw.
- R8: `bus_ready_o` is high only in the second cycle of the T3 or Tw that is followed by T4, so it is high for exactly one cycle per bus cycle, and the next cycle is in T4.
- R9: At the phase-2 edge that ends T4, the state becomes T1 if `start_i` is high, and idle otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Bus cycle request, sampled on phase-2 edges in idle and T4 |
| ardy_i | input | 1 | Asynchronous ready, two-stage capture |
| srdy_i | input | 1 | Synchronous ready, single-stage capture |
| tstate_o | output | 3 | Current T-state code |
| wait_o | output | 1 | High while in a wait state |
| bus_ready_o | output | 1 | High in the last cycle of the T3/Tw that ends the wait |
| phase_o | output | 1 | 1 when the coming edge is a phase-2 edge |

## Verification
A T-state change shows up one edge after the phase-2 edge that causes it. An asynchronous ready needs two edges, the phase-2 edge before the state and the phase-1 edge within it, and `bus_ready_o` rises in the cycle just after the phase-1 capture. The bench reads `tstate_o` and `phase_o` at each falling edge and from them knows which kind of edge comes next. It then sets each ready input for that edge alone: the value the sweep calls for at capture edges, and the opposite or a glitch value at the edges that must be ignored. It counts Tw cycles and strobes over the whole bus cycle, and compares the wait count with the smaller of the two first-ready indices.

// File: rtl/brs_pkg.sv
package brs_pkg;

    localparam int TSTATE_W = 3;

    typedef enum logic [TSTATE_W-1:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_TW   = 3'd4,
        TS_T4   = 3'd5
    } tstate_e;

    typedef enum logic {
        PH_ONE = 1'b0,
        PH_TWO = 1'b1
    } phase_e;

    // which kind of edge the coming rising edge is
    typedef struct packed {
        logic p1_edge;
        logic p2_edge;
    } edge_sel_t;

    // result of each ready capture path
    typedef struct packed {
        logic async_ok;
        logic sync_ok;
    } ready_paths_t;

    function automatic logic is_decision_state(tstate_e s);
        return (s == TS_T3) || (s == TS_TW);
    endfunction

    function automatic logic merge_ready(ready_paths_t r);
        return r.async_ok | r.sync_ok;
    endfunction

endpackage

// File: rtl/brs_phase_gen.sv
module brs_phase_gen
    import brs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    output phase_e    phase_o,
    output edge_sel_t edges_o
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ONE;
        end else begin
            phase_q <= (phase_q == PH_ONE) ? PH_TWO : PH_ONE;
        end
    end

    assign phase_o         = phase_q;
    assign edges_o.p1_edge = (phase_q == PH_ONE);
    assign edges_o.p2_edge = (phase_q == PH_TWO);

endmodule

// File: rtl/brs_async_capture.sv
module brs_async_capture
    import brs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  edge_sel_t edges_i,
    input  logic      ardy_i,
    output logic      ready_o
);

    logic first_q;
    logic second_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q  <= 1'b0;
            second_q <= 1'b0;
        end else begin
            if (edges_i.p2_edge) begin
                first_q <= ardy_i;
            end
            if (edges_i.p1_edge) begin
                // must still be high and must have been high at phase 2
                second_q <= ardy_i & first_q;
            end
        end
    end

    assign ready_o = second_q;

endmodule

// File: rtl/brs_sync_capture.sv
module brs_sync_capture
    import brs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  edge_sel_t edges_i,
    input  logic      srdy_i,
    output logic      ready_o
);

    logic cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= 1'b0;
        end else if (edges_i.p1_edge) begin
            cap_q <= srdy_i;
        end
    end

    assign ready_o = cap_q;

endmodule

// File: rtl/brs_tstate_fsm.sv
module brs_tstate_fsm
    import brs_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  edge_sel_t    edges_i,
    input  logic         start_i,
    input  ready_paths_t paths_i,
    output tstate_e      state_o,
    output logic         wait_o,
    output logic         done_o
);

    tstate_e state_q;
    tstate_e state_d;
    logic    rdy_any;

    assign rdy_any = merge_ready(paths_i);

    always_comb begin
        state_d = state_q;
        if (edges_i.p2_edge) begin
            unique case (state_q)
                TS_IDLE: state_d = start_i ? TS_T1 : TS_IDLE;
                TS_T1:   state_d = TS_T2;
                TS_T2:   state_d = TS_T3;
                TS_T3,
                TS_TW:   state_d = rdy_any ? TS_T4 : TS_TW;
                TS_T4:   state_d = start_i ? TS_T1 : TS_IDLE;
                default: state_d = TS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;
    assign wait_o  = (state_q == TS_TW);
    assign done_o  = is_decision_state(state_q) & edges_i.p2_edge & rdy_any;

endmodule

// File: rtl/dual_ready_sampler.sv
module dual_ready_sampler
    import brs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                ardy_i,
    input  logic                srdy_i,
    output logic [TSTATE_W-1:0] tstate_o,
    output logic                wait_o,
    output logic                bus_ready_o,
    output logic                phase_o
);

    phase_e       phase_w;
    edge_sel_t    edges_w;
    ready_paths_t paths_w;
    tstate_e      state_w;

    brs_phase_gen u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase_w),
        .edges_o (edges_w)
    );

    brs_async_capture u_async (
        .clk     (clk),
        .rst     (rst),
        .edges_i (edges_w),
        .ardy_i  (ardy_i),
        .ready_o (paths_w.async_ok)
    );

    brs_sync_capture u_sync (
        .clk     (clk),
        .rst     (rst),
        .edges_i (edges_w),
        .srdy_i  (srdy_i),
        .ready_o (paths_w.sync_ok)
    );

    brs_tstate_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .edges_i (edges_w),
        .start_i (start_i),
        .paths_i (paths_w),
        .state_o (state_w),
        .wait_o  (wait_o),
        .done_o  (bus_ready_o)
    );

    assign tstate_o = state_w;
    assign phase_o  = (phase_w == PH_TWO);

endmodule

// File: rtl/dual_ready_sampler_chk.sv
module dual_ready_sampler_chk
    import brs_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start_i,
    input logic [TSTATE_W-1:0] tstate_o,
    input logic                wait_o,
    input logic                bus_ready_o,
    input logic                phase_o
);

    logic live_q = 1'b0;
    logic rst_q  = 1'b0;

    always_ff @(posedge clk) begin
        live_q <= !rst;
        rst_q  <= rst;
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst_q |-> (tstate_o == TS_IDLE) && !phase_o && !bus_ready_o);

    // R2
    a_r2_phase_toggle: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (phase_o != $past(phase_o)));

    // R2
    a_r2_hold_on_p1: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(phase_o)) |-> (tstate_o == $past(tstate_o)));

    // R3
    a_r3_t1_to_t2: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(tstate_o == TS_T1 && phase_o)) |-> (tstate_o == TS_T2));

    // R6, R7
    a_r6_unready_waits: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past((tstate_o == TS_T3 || tstate_o == TS_TW) && phase_o && !bus_ready_o))
            |-> (tstate_o == TS_TW) && wait_o);

    // R8
    a_r8_strobe_to_t4: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(bus_ready_o)) |-> (tstate_o == TS_T4));

    // R8
    a_r8_strobe_window: assert property (@(posedge clk) disable iff (rst)
        bus_ready_o |-> phase_o && (tstate_o == TS_T3 || tstate_o == TS_TW));

    // R9
    a_r9_chain: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(tstate_o == TS_T4 && phase_o && start_i)) |-> (tstate_o == TS_T1));

endmodule

bind dual_ready_sampler dual_ready_sampler_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .tstate_o    (tstate_o),
    .wait_o      (wait_o),
    .bus_ready_o (bus_ready_o),
    .phase_o     (phase_o)
);

// File: tb/dual_ready_sampler_bench.sv
`timescale 1ns/1ps
module dual_ready_sampler_bench;
    import brs_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       ardy_i = 1'b0;
    logic       srdy_i = 1'b0;
    logic [2:0] tstate_o;
    logic       wait_o;
    logic       bus_ready_o;
    logic       phase_o;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    dual_ready_sampler u_dual_ready_sampler (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .ardy_i      (ardy_i),
        .srdy_i      (srdy_i),
        .tstate_o    (tstate_o),
        .wait_o      (wait_o),
        .bus_ready_o (bus_ready_o),
        .phase_o     (phase_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++;
            $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ARDY level for a capture edge belonging to T3/Tw number idx
    function automatic logic ardy_level(input int idx, input bit is_p2,
                                        input int a_from, input int mode);
        if (mode == 1 && idx == 0 && a_from > 0) return is_p2;   // drops before phase 1
        if (mode == 2 && idx == 0 && a_from > 0) return !is_p2;  // rises after phase 2
        return idx >= a_from;
    endfunction

    task automatic run_cycle(input int a_from, input int s_from, input int mode,
                             input bit chain, input bit pre_t1);
        int  done_idx = 0;
        int  tw_cyc   = 0;
        int  br_cnt   = 0;
        int  wmis     = 0;
        int  t1c      = pre_t1 ? 1 : 0;
        int  t2c      = 0;
        int  t3c      = 0;
        int  guard    = 0;
        bit  prev_br  = 1'b0;
        bit  br_to_t4 = 1'b1;
        bit  fin      = 1'b0;
        int  exp_w    = (a_from < s_from) ? a_from : s_from;
        string wtag   = (a_from <= s_from) ? "R4" : "R5";
        while (!fin && guard < 400) begin
            logic a;
            logic s;
            logic st_req;
            @(negedge clk);
            guard++;
            if (prev_br && tstate_o != TS_T4) br_to_t4 = 1'b0;
            prev_br = bus_ready_o;
            if (bus_ready_o) br_cnt++;
            if (wait_o != (tstate_o == TS_TW)) wmis++;
            case (tstate_o)
                TS_T1: t1c++;
                TS_T2: t2c++;
                TS_T3: t3c++;
                TS_TW: tw_cyc++;
                default: ;
            endcase
            a = 1'b1;
            s = 1'b1;
            st_req = 1'b0;
            if (tstate_o == TS_IDLE) st_req = 1'b1;
            if (tstate_o == TS_T2 && phase_o) a = ardy_level(0, 1'b1, a_from, mode);
            if (tstate_o == TS_T3 || tstate_o == TS_TW) begin
                if (phase_o) begin
                    a = ardy_level(done_idx + 1, 1'b1, a_from, mode);
                    s = !(done_idx >= s_from);   // noise at a phase-2 edge (R5)
                    done_idx++;
                end else begin
                    a = ardy_level(done_idx, 1'b0, a_from, mode);
                    s = (done_idx >= s_from);
                end
            end
            if (tstate_o == TS_T4) begin
                st_req = chain;
                if (phase_o) fin = 1'b1;
            end
            ardy_i  = a;
            srdy_i  = s;
            start_i = st_req;
        end
        @(negedge clk);
        chk(tstate_o == (chain ? TS_T1 : TS_IDLE), "R9", "state after T4",
            tstate_o, chain ? TS_T1 : TS_IDLE);
        ardy_i  = 1'b1;
        srdy_i  = 1'b1;
        start_i = 1'b0;
        chk(guard < 400, "R6", "bus cycle completed", guard, 400);
        chk(tw_cyc == 2 * exp_w, {wtag, "/R6"}, "wait cycles", tw_cyc, 2 * exp_w);
        chk(wmis == 0, "R7", "wait_o mismatches", wmis, 0);
        chk(br_cnt == 1, "R8", "bus_ready strobes", br_cnt, 1);
        chk(br_to_t4, "R8", "strobe followed by T4", br_to_t4, 1);
        chk(t1c == 2 && t2c == 2, "R3", "T1/T2 cycles", t1c * 10 + t2c, 22);
        chk(t3c == 2, "R2", "T3 cycles", t3c, 2);
    endtask

    initial begin
        int  n;
        bit  prev_chain;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tstate_o == TS_IDLE, "R1", "tstate in reset", tstate_o, TS_IDLE);
        chk(phase_o == 1'b0, "R1", "phase in reset", phase_o, 0);
        chk(!wait_o && !bus_ready_o, "R1", "outputs in reset", wait_o + bus_ready_o, 0);
        rst = 1'b0;
        // R2 phase alternation, R3 idle holds without start
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(phase_o == ((i % 2) == 0), "R2", "phase toggle", phase_o, (i % 2) == 0);
            chk(tstate_o == TS_IDLE, "R3", "idle without start", tstate_o, TS_IDLE);
        end
        // sweep of ready timing: first-ready index per path and ARDY glitch modes
        n = 0;
        prev_chain = 1'b0;
        for (int a = 0; a < 4; a++) begin
            for (int s = 0; s < 4; s++) begin
                for (int m = 0; m < 3; m++) begin
                    bit ch;
                    ch = (n % 2) == 1;
                    run_cycle(a, s, m, ch, prev_chain);
                    prev_chain = ch;
                    n++;
                end
            end
        end
        // R4: ARDY never valid, SRDY at index 5 gives five wait states
        run_cycle(9, 5, 0, 1'b0, prev_chain);
        // R1: reset in the middle of a bus cycle
        start_i = 1'b1;
        for (int i = 0; i < 20 && tstate_o != TS_T2; i++) @(negedge clk);
        start_i = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(tstate_o == TS_IDLE, "R1", "tstate after mid-cycle reset", tstate_o, TS_IDLE);
        chk(phase_o == 1'b0, "R1", "phase after mid-cycle reset", phase_o, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule